// File: doc/BRIEF.md
# SPI Mode-Fault and Overflow Error Monitor

This block sits beside an SPI port that can run as master or as slave and watches for the two error conditions such a port can meet. A mode fault means another device is driving the select line against the port's role. A slave sees this when its select is released in the middle of a transfer. A master sees it whenever its select input is pulled low. An overflow means a complete byte arrived from the shift register while the previous byte still sat unread in the receive data register.

The block brings the raw select pin through a synchronizer and then judges the mode fault according to the current role. It owns the receive data register and keeps the unread byte there when an overflow happens. It also holds the control bits (mode-fault detection enable and error interrupt enable) and the two error flags, and it drives one registered error interrupt request. Each flag is cleared by a two-step software sequence. The shift register and the serial clock generation are outside the block.

Top module: `spi_fault_monitor`

## Requirements
- R1: After a synchronous reset, mode_fault, overflow, rx_full, fault_en, err_ie and err_irq are all 0.
- R2: As slave (is_master=0) with fault_en=1, a low-to-high change of the synchronized select while xfer_active=1 sets mode_fault.
- R3: As slave, a rising select while xfer_active=0 leaves mode_fault at 0.
- R4: As master (is_master=1) with fault_en=1, a synchronized select level of 0 sets mode_fault at any time, whether or not a transfer is active.
- R5: With fault_en=0, mode_fault never sets, in either role.
- R6: A byte_done pulse while the receive register is empty loads shift_byte into rx_data and sets rx_full. A data_rd pulse clears rx_full.
- R7: A byte_done pulse while rx_full=1 and data_rd=0 sets overflow. rx_data keeps the unread byte and the new byte is dropped.
- R8: overflow clears only on a data_rd that follows a stat_rd made while overflow was 1. A data_rd without that earlier status read leaves overflow set.
- R9: mode_fault clears only on a ctrl_wr that follows a stat_rd made while mode_fault was 1. A ctrl_wr without that earlier status read leaves it set. A new fault event in the same cycle as the clearing write wins.
- R10: err_irq equals err_ie AND (mode_fault OR overflow), and changes on the same clock edge as the flags.
- R11: The select pin passes through a two-flop synchronizer. A fault caused by a pin change shows on mode_fault at the third rising clock edge after the pin changes.
- R12: byte_done and data_rd in the same cycle while rx_full=1 load the new byte, keep rx_full at 1 and leave overflow unchanged.
- R13: ctrl_wr loads fault_en from wr_fault_en and err_ie from wr_err_ie. A fault check in that same cycle still uses the previous fault_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ssel_pin | input | 1 | Raw slave-select pin, active low |
| is_master | input | 1 | Role bit: 1 = master, 0 = slave |
| xfer_active | input | 1 | Transfer in progress |
| byte_done | input | 1 | Strobe: shift register holds a full byte |
| shift_byte | input | DATA_W | Byte from the shift register |
| data_rd | input | 1 | CPU read of the receive data register |
| stat_rd | input | 1 | CPU read of the status/control register |
| ctrl_wr | input | 1 | CPU write of the status/control register |
| wr_fault_en | input | 1 | Written value of the mode-fault enable |
| wr_err_ie | input | 1 | Written value of the error interrupt enable |
| rx_data | output | DATA_W | Receive data register |
| rx_full | output | 1 | Receive register holds an unread byte |
| mode_fault | output | 1 | Mode-fault flag |
| overflow | output | 1 | Overflow flag |
| fault_en | output | 1 | Mode-fault detection enable |
| err_ie | output | 1 | Error interrupt enable |
| err_irq | output | 1 | Combined error interrupt request |

## Verification
The hardest case to reach is a collision between a flag's clearing step and a new error of the same kind. One such case is a ctrl_wr that clears mode_fault arriving on the same edge as a fresh master-mode fault. Another is a data_rd that completes the overflow clear while byte_done also fires. The stimulus first arms the clear with a status read. It then times the select pin change three edges ahead so the synchronized level lands on the write cycle, and it places byte_done on the very cycle of the read. A behavioural model checks every output on every clock.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  localparam int MIN_SYNC = 2;

  typedef struct packed {
    logic fault_en;
    logic err_ie;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{fault_en: 1'b0, err_ie: 1'b0};
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int N = (STAGES < spi_fault_pkg::MIN_SYNC) ? spi_fault_pkg::MIN_SYNC : STAGES;

  logic [N-1:0] chain;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[N-1];
endmodule

// File: rtl/mode_fault_det.sv
module mode_fault_det (
  input  logic clk,
  input  logic rst,
  input  logic ss_lvl,
  input  logic is_master,
  input  logic xfer_active,
  input  logic fault_en,
  input  logic stat_rd,
  input  logic ctrl_wr,
  output logic mode_fault,
  output logic mf_next
);
  logic ss_prev;
  logic armed;
  logic slave_ev, master_ev, fault_ev, clr;

  always_comb begin
    slave_ev  = !is_master && xfer_active && ss_lvl && !ss_prev;
    master_ev = is_master && !ss_lvl;
    fault_ev  = fault_en && (slave_ev || master_ev);
    clr       = ctrl_wr && armed;
    if (fault_ev)  mf_next = 1'b1;
    else if (clr)  mf_next = 1'b0;
    else           mf_next = mode_fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_prev    <= 1'b1;
      armed      <= 1'b0;
      mode_fault <= 1'b0;
    end else begin
      ss_prev    <= ss_lvl;
      mode_fault <= mf_next;
      if (clr)                     armed <= 1'b0;
      else if (stat_rd && mode_fault) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_overflow_det.sv
module rx_overflow_det #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] shift_byte,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overflow,
  output logic              ov_next
);
  logic armed;
  logic load, lose, clr;

  always_comb begin
    load = byte_done && (!rx_full || data_rd);
    lose = byte_done && rx_full && !data_rd;
    clr  = data_rd && armed;
    if (lose)      ov_next = 1'b1;
    else if (clr)  ov_next = 1'b0;
    else           ov_next = overflow;
  end

  always_ff @(posedge clk) begin
    if (load) rx_data <= shift_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full  <= 1'b0;
      overflow <= 1'b0;
      armed    <= 1'b0;
    end else begin
      overflow <= ov_next;
      if (load)         rx_full <= 1'b1;
      else if (data_rd) rx_full <= 1'b0;
      if (clr)                      armed <= 1'b0;
      else if (stat_rd && overflow) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_fault_monitor.sv
module spi_fault_monitor #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ssel_pin,
  input  logic              is_master,
  input  logic              xfer_active,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] shift_byte,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              ctrl_wr,
  input  logic              wr_fault_en,
  input  logic              wr_err_ie,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              mode_fault,
  output logic              overflow,
  output logic              fault_en,
  output logic              err_ie,
  output logic              err_irq
);
  import spi_fault_pkg::*;

  ctrl_t ctrl_q, ctrl_d;
  logic  ss_lvl;
  logic  mf_next, ov_next;

  ss_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk), .rst (rst), .din (ssel_pin), .dout (ss_lvl)
  );

  mode_fault_det u_mf (
    .clk (clk), .rst (rst), .ss_lvl (ss_lvl), .is_master (is_master),
    .xfer_active (xfer_active), .fault_en (ctrl_q.fault_en),
    .stat_rd (stat_rd), .ctrl_wr (ctrl_wr),
    .mode_fault (mode_fault), .mf_next (mf_next)
  );

  rx_overflow_det #(.DATA_W(DATA_W)) u_ov (
    .clk (clk), .rst (rst), .byte_done (byte_done), .shift_byte (shift_byte),
    .data_rd (data_rd), .stat_rd (stat_rd),
    .rx_data (rx_data), .rx_full (rx_full), .overflow (overflow), .ov_next (ov_next)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.fault_en = wr_fault_en;
      ctrl_d.err_ie   = wr_err_ie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RESET;
      err_irq <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      err_irq <= ctrl_d.err_ie && (mf_next || ov_next);
    end
  end

  assign fault_en = ctrl_q.fault_en;
  assign err_ie   = ctrl_q.err_ie;
endmodule

// File: rtl/spi_fault_monitor_chk.sv
module spi_fault_monitor_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ss_lvl,
  input logic              is_master,
  input logic              byte_done,
  input logic              data_rd,
  input logic              ctrl_wr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              mode_fault,
  input logic              overflow,
  input logic              fault_en,
  input logic              err_ie,
  input logic              err_irq
);
  // R4
  master_fault_chk: assert property (@(posedge clk) disable iff (rst)
    is_master && fault_en && !ss_lvl |=> mode_fault);
  // R5
  no_fault_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_en && !mode_fault |=> !mode_fault);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done && rx_full && !data_rd |=> overflow && $stable(rx_data));
  // R8
  overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    overflow && !data_rd |=> overflow);
  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mode_fault && !ctrl_wr |=> mode_fault);
  // R10
  irq_combine_chk: assert property (@(posedge clk) disable iff (rst)
    err_irq == (err_ie && (mode_fault || overflow)));
endmodule

bind spi_fault_monitor spi_fault_monitor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk (clk), .rst (rst), .ss_lvl (ss_lvl), .is_master (is_master),
  .byte_done (byte_done), .data_rd (data_rd), .ctrl_wr (ctrl_wr),
  .rx_data (rx_data), .rx_full (rx_full), .mode_fault (mode_fault),
  .overflow (overflow), .fault_en (fault_en), .err_ie (err_ie), .err_irq (err_irq)
);

// File: tb/spi_fault_monitor_test.sv
module spi_fault_monitor_test;
  localparam int DW = 8;
  localparam int NS = 2;

  logic clk = 0;
  logic rst = 1;
  logic ssel_pin = 1, is_master = 0, xfer_active = 0, byte_done = 0;
  logic [DW-1:0] shift_byte = '0;
  logic data_rd = 0, stat_rd = 0, ctrl_wr = 0, wr_fault_en = 0, wr_err_ie = 0;
  logic [DW-1:0] rx_data;
  logic rx_full, mode_fault, overflow, fault_en, err_ie, err_irq;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_fault_monitor #(.DATA_W(DW), .SYNC_STAGES(NS)) uut (
    .clk(clk), .rst(rst), .ssel_pin(ssel_pin), .is_master(is_master),
    .xfer_active(xfer_active), .byte_done(byte_done), .shift_byte(shift_byte),
    .data_rd(data_rd), .stat_rd(stat_rd), .ctrl_wr(ctrl_wr),
    .wr_fault_en(wr_fault_en), .wr_err_ie(wr_err_ie),
    .rx_data(rx_data), .rx_full(rx_full), .mode_fault(mode_fault),
    .overflow(overflow), .fault_en(fault_en), .err_ie(err_ie), .err_irq(err_irq));

  // behavioural reference state
  bit ssq[$];
  bit m_prev, m_mf, m_ov, m_full, m_fen, m_ie, m_irq, m_arm_mf, m_arm_ov;
  int m_data;
  bit data_known;

  always @(posedge clk) begin
    bit lvl, ev, mfc, lose, load, ovc, n_mf, n_ov, n_fen, n_ie;
    if (rst) begin
      ssq.delete();
      for (int i = 0; i < NS; i++) ssq.push_back(1'b1);
      m_prev = 1; m_mf = 0; m_ov = 0; m_full = 0; m_fen = 0; m_ie = 0;
      m_irq = 0; m_arm_mf = 0; m_arm_ov = 0;
    end else begin
      lvl  = ssq[NS-1];
      ev   = m_fen && ((!is_master && xfer_active && lvl && !m_prev) || (is_master && !lvl));
      mfc  = ctrl_wr && m_arm_mf;
      n_mf = ev ? 1'b1 : (mfc ? 1'b0 : m_mf);
      lose = byte_done && m_full && !data_rd;
      load = byte_done && !lose;
      ovc  = data_rd && m_arm_ov;
      n_ov = lose ? 1'b1 : (ovc ? 1'b0 : m_ov);
      n_fen = ctrl_wr ? wr_fault_en : m_fen;
      n_ie  = ctrl_wr ? wr_err_ie : m_ie;
      if (mfc) m_arm_mf = 0; else if (stat_rd && m_mf) m_arm_mf = 1;
      if (ovc) m_arm_ov = 0; else if (stat_rd && m_ov) m_arm_ov = 1;
      if (load) begin m_data = int'(shift_byte); m_full = 1; data_known = 1; end
      else if (data_rd) m_full = 0;
      m_prev = lvl;
      ssq.push_front(ssel_pin); void'(ssq.pop_back());
      m_mf = n_mf; m_ov = n_ov; m_fen = n_fen; m_ie = n_ie;
      m_irq = n_ie && (n_mf || n_ov);
    end
  end

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      cmp("R2/R4/R9", "mode_fault", int'(mode_fault), int'(m_mf));
      cmp("R7/R8", "overflow", int'(overflow), int'(m_ov));
      cmp("R6", "rx_full", int'(rx_full), int'(m_full));
      cmp("R13", "fault_en", int'(fault_en), int'(m_fen));
      cmp("R13", "err_ie", int'(err_ie), int'(m_ie));
      cmp("R10", "err_irq", int'(err_irq), int'(m_irq));
      if (data_known) cmp("R6/R7", "rx_data", int'(rx_data), m_data);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      byte_done = 0; data_rd = 0; stat_rd = 0; ctrl_wr = 0;
    end
  endtask

  task automatic wr_ctrl(input bit fe, input bit ie);
    ctrl_wr = 1; wr_fault_en = fe; wr_err_ie = ie; tick();
  endtask

  task automatic push_byte(input logic [DW-1:0] b);
    byte_done = 1; shift_byte = b; tick();
  endtask

  task automatic clear_mf();
    stat_rd = 1; tick(); ctrl_wr = 1; tick();
  endtask

  initial begin
    fork
      begin
        #3_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    rst = 1; tick(3); rst = 0; #2;
    // R1 reset values
    cmp("R1", "mode_fault", mode_fault, 0); cmp("R1", "overflow", overflow, 0);
    cmp("R1", "rx_full", rx_full, 0); cmp("R1", "err_irq", err_irq, 0);
    cmp("R1", "fault_en", fault_en, 0); cmp("R1", "err_ie", err_ie, 0);

    // R5 disabled: slave rising during transfer and master low select
    xfer_active = 1; ssel_pin = 0; tick(4); ssel_pin = 1; tick(4);
    is_master = 1; ssel_pin = 0; tick(4);
    #2 cmp("R5", "mode_fault off", mode_fault, 0);
    ssel_pin = 1; is_master = 0; tick(4);

    // R13 enable both
    wr_ctrl(1, 1);
    #2 cmp("R13", "fault_en", fault_en, 1);

    // R3 slave rising without transfer
    xfer_active = 0; ssel_pin = 0; tick(4); ssel_pin = 1; tick(4);
    #2 cmp("R3", "mode_fault idle", mode_fault, 0);

    // R2 + R11 slave rising during transfer: flag on third edge
    ssel_pin = 0; tick(4); xfer_active = 1; ssel_pin = 1;
    tick(2); #2 cmp("R11", "mf after 2 edges", mode_fault, 0);
    tick(1); #2 cmp("R2", "slave fault", mode_fault, 1);
    cmp("R10", "irq on fault", err_irq, 1);
    xfer_active = 0;

    // R9 control write without status read leaves flag
    wr_ctrl(1, 1); #2 cmp("R9", "no clear w/o status", mode_fault, 1);
    clear_mf(); #2 cmp("R9", "cleared", mode_fault, 0);

    // R4 master low select, no transfer
    is_master = 1; ssel_pin = 0; tick(3);
    #2 cmp("R4", "master fault", mode_fault, 1);
    // R9 clear collides with persistent fault: set wins
    clear_mf(); #2 cmp("R9", "set wins", mode_fault, 1);
    ssel_pin = 1; tick(3); clear_mf();
    #2 cmp("R9", "cleared after release", mode_fault, 0);
    is_master = 0;

    // R13 disable in same cycle as fault event uses old enable
    is_master = 1; ssel_pin = 0; tick(2);
    wr_ctrl(0, 1); #2 cmp("R13", "old enable used", mode_fault, 1);
    ssel_pin = 1; is_master = 0; tick(3); clear_mf();

    // R6 load and read
    push_byte(8'hA5); #2 cmp("R6", "full", rx_full, 1); cmp("R6", "data", rx_data, 8'hA5);
    data_rd = 1; tick(); #2 cmp("R6", "read empties", rx_full, 0);

    // R7 overflow keeps unread byte
    push_byte(8'h3C); push_byte(8'hC3);
    #2 cmp("R7", "overflow", overflow, 1); cmp("R7", "kept", rx_data, 8'h3C);
    // R8 data read without status read does not clear
    data_rd = 1; tick(); #2 cmp("R8", "no clear", overflow, 1);
    stat_rd = 1; tick(); data_rd = 1; tick();
    #2 cmp("R8", "cleared", overflow, 0);

    // R12 byte and read together while full
    push_byte(8'h11); byte_done = 1; data_rd = 1; shift_byte = 8'h22; tick();
    #2 cmp("R12", "no overflow", overflow, 0); cmp("R12", "new byte", rx_data, 8'h22);
    cmp("R12", "still full", rx_full, 1);

    // R10 irq gated by enable
    push_byte(8'h33); #2 cmp("R10", "irq", err_irq, 1);
    wr_ctrl(1, 0); #2 cmp("R10", "irq masked", err_irq, 0);
    wr_ctrl(1, 1); stat_rd = 1; tick(); data_rd = 1; byte_done = 1; shift_byte = 8'h44; tick();
    #2 cmp("R8", "clear with load", overflow, 0); cmp("R10", "irq low", err_irq, 0);
    tick(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule